// File: doc/BRIEF.md
# Frame-Synchronised Serial Port

This block moves one data word at a time across a single-bit serial line. Its clock is the bit clock, and every rising edge moves one bit. A word starts only when a frame sync is seen. The frame sync comes from one of two sources:

- **Internal:** a period counter generates it and drives it out on the frame sync pin.
- **External:** it is taken from the frame sync pin.

Three controls decide how the frame sync is read, and each can be set on its own:

- the frame sync source (internal or external);
- the active level (high or low);
- the alignment to the data (early or late).

In late alignment the first data bit is sampled on the same edge as the sync. In early alignment the first data bit is sampled on the edge after the sync. Words run from 3 to 32 bits, most significant bit first. One control bit sets the direction: transmit or receive.

Words for transmission enter through a one-entry buffer with a valid/ready handshake. `tx_ready` is high while the buffer is empty. A word is taken on any edge where `tx_valid` and `tx_ready` are both high. The held word is consumed when the next frame starts.

Received words leave on a single-cycle `rx_valid` pulse. A serial line cannot stall, so the receive side has no ready input and the consumer must take each word when it is presented.

Configuration is expected to change only while reset is asserted.

Top module: `sport_fsync`

## Requirements
- R1: No word is sampled or presented unless a frame sync was accepted first. Data bits on `sd_in` outside a frame never produce `rx_valid`.
- R2: With `cfg_fs_int`=1 the internal generator is the sync source and `fs_oe`=1. With `cfg_fs_int`=0 the sync is taken from `fs_in` and `fs_oe`=0.
- R3: With `cfg_fs_act_low`=0 the sync is active when the pin is 1. With `cfg_fs_act_low`=1 it is active when the pin is 0. The driven `fs_out` rests at the inactive level except during its one-cycle pulse.
- R4: Late mode (`cfg_fs_early`=0): the most significant bit is sampled on the same edge as the sync. The remaining bits follow on the next edges.
- R5: Early mode (`cfg_fs_early`=1): the most significant bit is sampled on the edge after the sync.
- R6: The word length `cfg_wlen` can be any value from 3 to 32. Bits go most significant first. Received words are right-justified in `rx_data` with the upper bits zero. A transmitted word uses the low `cfg_wlen` bits of `tx_data`.
- R7: The internal sync is active for one cycle out of every `cfg_period` cycles, where `cfg_period` is at least `cfg_wlen`.
- R8: `rx_valid` is high for exactly the one cycle after the edge that samples a word's last bit, with the word on `rx_data`.
- R9: `tx_ready`=1 while in transmit mode and the buffer is empty. After a handshake it is 0 until the next frame starts. A frame that starts with an empty buffer sends all zeros.
- R10: A sync that arrives while a word is still in progress is ignored and sets the sticky `fs_err` flag. Two frames may still abut with no gap:
  - in late mode, a sync on the edge right after the last bit is accepted;
  - in early mode, a sync on the last-bit edge itself is accepted.
- R11: `sd_oe` equals `cfg_tx`. `rx_valid` never rises in transmit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| cfg_tx | input | 1 | 1 = transmit, 0 = receive |
| cfg_fs_int | input | 1 | 1 = internal sync generator |
| cfg_fs_act_low | input | 1 | 1 = sync is active low |
| cfg_fs_early | input | 1 | 1 = early alignment |
| cfg_wlen | input | LW (6) | Word length, 3 to W |
| cfg_period | input | PW (8) | Internal sync period in clocks |
| fs_in | input | 1 | Frame sync pin, input side |
| fs_out | output | 1 | Frame sync pin, output side |
| fs_oe | output | 1 | Frame sync pin output enable |
| sd_in | input | 1 | Serial data in |
| sd_out | output | 1 | Serial data out |
| sd_oe | output | 1 | Serial data output enable |
| tx_data | input | W (32) | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit buffer empty |
| rx_data | output | W (32) | Received word |
| rx_valid | output | 1 | One-cycle received-word strobe |
| fs_err | output | 1 | Sticky sync-collision flag |

## Verification
The assertions check the following on every cycle:
- `rx_valid` is a single-cycle pulse and only follows an active frame.
- `fs_err` never clears once set.
- An idle `tx_ready` stays high.
- The internal sync pulse lasts one cycle.
- `rx_valid` stays low in transmit mode.

Only the bench scenarios can show bit order, the exact alignment in early and late modes, and the spacing between internal sync pulses. The same applies to frames that abut with no gap, words of all-zero underrun, and a colliding sync being dropped without corrupting the word in flight. For those, the bench compares whole received or transmitted words against values built from the requirements.

// File: rtl/sport_fsync_pkg.sv
package sport_fsync_pkg;
  typedef struct packed {
    logic tx;
    logic fs_int;
    logic act_low;
    logic early;
  } sport_mode_t;
endpackage

// File: rtl/sport_fs_gen.sv
// Internal frame sync generator: one-cycle pulse every `period` clocks.
module sport_fs_gen #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] period,
  output logic          pulse
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] cnt;
  logic          wrap;

  assign wrap  = (cnt >= period - ONE);
  assign pulse = en && (cnt == period - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (wrap)   cnt <= '0;
    else             cnt <= cnt + ONE;
  end
endmodule

// File: rtl/sport_frame_ctl.sv
// Bit counter: accepts or rejects frame syncs and marks sample/last edges.
module sport_frame_ctl #(
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fs_det,
  input  logic          early,
  input  logic [LW-1:0] wlen,
  output logic          start,
  output logic          sample,
  output logic          last,
  output logic          busy,
  output logic          err
);
  localparam logic [LW-1:0] ONE = LW'(1);

  logic [LW-1:0] rem;   // bits still to be sampled after this edge
  logic          open;

  // Early mode may take the next sync on the last-bit edge; late mode waits.
  assign open   = early ? (rem <= ONE) : (rem == '0);
  assign start  = fs_det && open;
  assign busy   = (rem != '0);
  assign last   = (rem == ONE);
  assign sample = busy || (start && !early);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0;
      err <= 1'b0;
    end else begin
      if (start)     rem <= early ? wlen : wlen - ONE;
      else if (busy) rem <= rem - ONE;
      if (fs_det && !open) err <= 1'b1;
    end
  end
endmodule

// File: rtl/sport_rx_path.sv
// Receive shifter: collects bits MSB first, emits right-justified word.
module sport_rx_path #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         start,
  input  logic         early,
  input  logic         sample,
  input  logic         last,
  input  logic         sd_in,
  output logic [W-1:0] rx_data,
  output logic         rx_valid
);
  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= en && last;
      if (en && last) rx_data <= {sh[W-2:0], sd_in};
      if (start && !early)  sh <= {{(W-1){1'b0}}, sd_in};
      else if (start)       sh <= '0;
      else if (sample)      sh <= {sh[W-2:0], sd_in};
    end
  end
endmodule

// File: rtl/sport_tx_path.sv
// Transmit side: one-word buffer with valid/ready, left-aligned shifter.
module sport_tx_path #(
  parameter int W  = 32,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          start,
  input  logic          early,
  input  logic          busy,
  input  logic [LW-1:0] wlen,
  input  logic [W-1:0]  tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic          sd_out
);
  localparam logic [LW-1:0] WL = LW'(W);

  logic [W-1:0] hold;
  logic         full;
  logic [W-1:0] sh;
  logic [W-1:0] nxt_al;

  // Next word placed so its MSB sits at the top bit; empty buffer sends zeros.
  assign nxt_al   = (full ? hold : '0) << (WL - wlen);
  assign tx_ready = en && !full;

  always_comb begin
    if (!en)       sd_out = 1'b0;
    else if (busy) sd_out = sh[W-1];
    else if (!early) sd_out = nxt_al[W-1];
    else           sd_out = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
      full <= 1'b0;
      sh   <= '0;
    end else begin
      if (start && en) full <= 1'b0;
      if (tx_valid && tx_ready) begin
        hold <= tx_data;
        full <= 1'b1;
      end
      if (start)     sh <= early ? nxt_al : (nxt_al << 1);
      else if (busy) sh <= sh << 1;
    end
  end
endmodule

// File: rtl/sport_fsync.sv
module sport_fsync
  import sport_fsync_pkg::*;
#(
  parameter int W  = 32,
  parameter int PW = 8,
  localparam int LW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_tx,
  input  logic          cfg_fs_int,
  input  logic          cfg_fs_act_low,
  input  logic          cfg_fs_early,
  input  logic [LW-1:0] cfg_wlen,
  input  logic [PW-1:0] cfg_period,
  input  logic          fs_in,
  output logic          fs_out,
  output logic          fs_oe,
  input  logic          sd_in,
  output logic          sd_out,
  output logic          sd_oe,
  input  logic [W-1:0]  tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic [W-1:0]  rx_data,
  output logic          rx_valid,
  output logic          fs_err
);
  sport_mode_t mode;
  logic gen_pulse, fs_det;
  logic start, sample, last, busy;

  assign mode = '{tx: cfg_tx, fs_int: cfg_fs_int,
                  act_low: cfg_fs_act_low, early: cfg_fs_early};

  sport_fs_gen #(.PW(PW)) u_gen (
    .clk(clk), .rst_n(rst_n), .en(mode.fs_int),
    .period(cfg_period), .pulse(gen_pulse)
  );

  assign fs_det = mode.fs_int ? gen_pulse : (fs_in ^ mode.act_low);
  assign fs_out = gen_pulse ^ mode.act_low;
  assign fs_oe  = mode.fs_int;
  assign sd_oe  = mode.tx;

  sport_frame_ctl #(.LW(LW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .fs_det(fs_det), .early(mode.early),
    .wlen(cfg_wlen), .start(start), .sample(sample), .last(last),
    .busy(busy), .err(fs_err)
  );

  sport_rx_path #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(!mode.tx), .start(start),
    .early(mode.early), .sample(sample), .last(last), .sd_in(sd_in),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  sport_tx_path #(.W(W), .LW(LW)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(mode.tx), .start(start),
    .early(mode.early), .busy(busy), .wlen(cfg_wlen),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .sd_out(sd_out)
  );
endmodule

// File: rtl/sport_fsync_chk.sv
module sport_fsync_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_tx,
  input logic cfg_fs_int,
  input logic cfg_fs_act_low,
  input logic fs_out,
  input logic rx_valid,
  input logic tx_valid,
  input logic tx_ready,
  input logic busy,
  input logic fs_err
);
  p_valid_after_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(busy));

  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_int_pulse_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fs_int && (fs_out != cfg_fs_act_low)) |=> (fs_out == cfg_fs_act_low));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fs_err |=> fs_err);

  p_ready_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid && cfg_tx) |=> (tx_ready || !cfg_tx));

  p_tx_no_rx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_tx && $past(cfg_tx)) |-> !rx_valid);
endmodule

bind sport_fsync sport_fsync_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_tx(cfg_tx), .cfg_fs_int(cfg_fs_int),
  .cfg_fs_act_low(cfg_fs_act_low), .fs_out(fs_out), .rx_valid(rx_valid),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .busy(busy), .fs_err(fs_err)
);

// File: tb/test_sport_fsync.sv
module test_sport_fsync;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_tx, cfg_fs_int, cfg_fs_act_low, cfg_fs_early;
  logic [5:0]  cfg_wlen;
  logic [7:0]  cfg_period;
  logic        fs_in, sd_in, tx_valid;
  logic [31:0] tx_data;
  logic        fs_out, fs_oe, sd_out, sd_oe, tx_ready, rx_valid, fs_err;
  logic [31:0] rx_data;

  sport_fsync i_sport_fsync (.*);

  always #5 clk = ~clk;

  int nvec = 0, nfail = 0, cyc = 0, last_fs = -1;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic        fsA [512];
  logic        sdA [512];
  logic        vexp[512];
  logic [31:0] dexp[512];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input int l);
    return (l == 32) ? 32'hFFFF_FFFF : ((32'd1 << l) - 32'd1);
  endfunction

  // Applies configuration under reset; returns just after a negedge.
  task automatic setup(input bit tx, input bit fint, input bit alow, input bit early,
                       input int l, input int p);
    rst_n = 0;
    cfg_tx = tx; cfg_fs_int = fint; cfg_fs_act_low = alow; cfg_fs_early = early;
    cfg_wlen = 6'(l); cfg_period = 8'(p);
    fs_in = alow; sd_in = 0; tx_valid = 0; tx_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // ---------------- receive stream player ----------------
  task automatic clear_stream();
    for (int i = 0; i < 512; i++) begin
      fsA[i] = 0; sdA[i] = 1'($urandom); vexp[i] = 0; dexp[i] = 0;
    end
  endtask

  task automatic place(input int p, input logic [31:0] w, input int l, input bit early);
    int off = early ? 1 : 0;
    fsA[p] = 1;
    for (int i = 0; i < l; i++) sdA[p + off + i] = w[l-1-i];
    vexp[p + off + l] = 1;
    dexp[p + off + l] = w & mask_of(l);
  endtask

  task automatic play(input int n);
    for (int k = 0; k < n + 2; k++) begin
      if (rx_valid || vexp[k])   // R8 timing / R1 no spurious words / R6 data
        chk(rx_valid == vexp[k] && (!vexp[k] || rx_data == dexp[k]),
            "R8/R6 rx word", rx_valid ? rx_data : 32'hDEAD, dexp[k]);
      fs_in = (k < n) ? (fsA[k] ^ cfg_fs_act_low) : cfg_fs_act_low;
      sd_in = (k < n) ? sdA[k] : 1'b0;
      @(negedge clk);
    end
  endtask

  // ---------------- transmit helpers ----------------
  task automatic load(input logic [31:0] w);
    tx_data = w; tx_valid = 1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 0;
    chk(tx_ready == 0, "R9 ready low while word held", tx_ready, 0);
  endtask

  task automatic tx_frame(input bit ext, input bit loaded, input logic [31:0] w, input int p);
    logic [31:0] got = 0;
    bit rxseen = 0;
    int l = cfg_wlen;
    if (loaded) load(w);
    if (ext) begin
      repeat ($urandom % 3) @(negedge clk);
      fs_in = ~cfg_fs_act_low;
    end else begin
      while ((fs_out ^ cfg_fs_act_low) != 1'b1) @(negedge clk);
      if (last_fs >= 0) chk(cyc - last_fs == p, "R7 internal sync spacing", cyc - last_fs, p);
      last_fs = cyc;
    end
    if (!cfg_fs_early) got = {got[30:0], sd_out};   // R4 MSB on sync edge
    for (int i = 0; i < (cfg_fs_early ? l : l - 1); i++) begin
      @(negedge clk);
      if (ext) fs_in = cfg_fs_act_low;
      if (!ext && i == 0)
        chk(fs_out == cfg_fs_act_low, "R3 fs_out rests inactive", fs_out, cfg_fs_act_low);
      if (rx_valid) rxseen = 1;
      got = {got[30:0], sd_out};
    end
    chk(got == (loaded ? (w & mask_of(l)) : 32'h0),
        cfg_fs_early ? "R5/R6 tx word early" : "R4/R6 tx word late", got,
        loaded ? (w & mask_of(l)) : 32'h0);
    chk(!rxseen, "R11 no rx_valid in tx mode", rxseen, 0);
    @(negedge clk);
    chk(tx_ready == 1, "R9 ready after frame start", tx_ready, 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));

    // Reset state
    setup(1, 0, 0, 0, 8, 12);
    chk(rx_valid == 0, "R8 reset rx_valid", rx_valid, 0);
    chk(fs_err == 0, "R10 reset fs_err", fs_err, 0);
    chk(tx_ready == 1, "R9 reset tx_ready", tx_ready, 1);
    chk(sd_oe == 1, "R11 sd_oe in tx", sd_oe, 1);
    chk(fs_oe == 0, "R2 fs_oe external", fs_oe, 0);

    // Receive, external sync, random modes, abutting frames included (R4 R5 R10)
    for (int sc = 0; sc < 10; sc++) begin
      int l = 3 + ($urandom % 30);
      bit early = (sc < 2) ? sc[0] : 1'($urandom);
      bit alow = 1'($urandom);
      int p = 2 + ($urandom % 4);
      setup(0, 0, alow, early, l, 40);
      chk(sd_oe == 0, "R11 sd_oe in rx", sd_oe, 0);
      clear_stream();
      while (p + l + 3 < 500) begin
        place(p, $urandom, l, early);
        p = p + l + ((sc < 2) ? 0 : ($urandom % 4));
      end
      play(500);
      chk(fs_err == 0, "R10 abutting syncs accepted", fs_err, 0);
    end

    // Collision in late mode: extra sync ignored, flag set (R10)
    setup(0, 0, 0, 0, 8, 40);
    clear_stream();
    place(10, 32'hA5, 8, 0);
    fsA[13] = 1;
    place(30, 32'h3C, 8, 0);
    play(60);
    chk(fs_err == 1, "R10 late collision flag", fs_err, 1);

    // Collision in early mode, active-low sync (R10, R3)
    setup(0, 0, 1, 1, 5, 40);
    clear_stream();
    place(10, 32'h13, 5, 1);
    fsA[13] = 1;
    place(25, 32'h0A, 5, 1);
    play(50);
    chk(fs_err == 1, "R10 early collision flag", fs_err, 1);

    // Transmit with internal sync (R2 R3 R7 R4 R5)
    for (int sc = 0; sc < 4; sc++) begin
      int l = 3 + ($urandom % 30);
      int p = l + 2 + ($urandom % 6);
      setup(1, 1, 1'(sc), 1'(sc >> 1), l, p);
      chk(fs_oe == 1, "R2 fs_oe internal", fs_oe, 1);
      last_fs = -1;
      for (int f = 0; f < 5; f++) tx_frame(0, 1, $urandom, p);
    end

    // Transmit with external sync, plus underrun (R2 R9 R6)
    for (int sc = 0; sc < 4; sc++) begin
      int l = (sc == 0) ? 32 : (sc == 1) ? 3 : 3 + ($urandom % 30);
      setup(1, 0, 1'($urandom), 1'(sc), l, 40);
      for (int f = 0; f < 4; f++) tx_frame(1, 1, $urandom, 0);
      tx_frame(1, 0, 32'h0, 0);   // R9 empty buffer sends zeros
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule